// File: doc/BRIEF.md
# Filter Run Sequencer

This block drives a single image-filter run across a byte-wide serial link. It waits for a command byte that names one of eight filters. When the byte is accepted, the block sends the same byte back as a handshake. It then passes a whole frame of pixel bytes from the link receiver to the filter, and passes the filtered bytes from the filter to the link transmitter. Each pixel moves in one direction per transfer.

After the last filtered byte leaves, the block sends a trailer. The trailer is a 32-bit count of the cycles in which the filter reported itself busy during the exchange. It goes out with the high byte first. Time spent waiting on the link is not counted. The trailer lets the host tell compute cost apart from transfer cost. The counter does not handle wrap, because a full run stays far below 2^32 cycles.

All byte interfaces use valid/ready handshakes. The link ports connect straight through to the filter ports inside the exchange phase, so no byte is buffered and none is dropped.

Top module: `seq_run_top`

## Requirements
- R1: In idle, a received byte with a value from 1 to 8 inclusive starts a run. That byte is sent back exactly once as the first transmitted byte.
- R2: While the echo is pending, no receive byte is accepted and no pixel reaches the filter. The first pixel moves only after the echo has been taken.
- R3: In idle, a received byte outside 1..8 is consumed and has no other effect. Nothing is transmitted, the run indicator stays low and the receiver stays ready.
- R4: During a run, exactly ROWS×COLS bytes are forwarded from the receiver to the filter, and exactly ROWS×COLS filtered bytes are forwarded to the transmitter. Both streams keep their order and values.
- R5: After the last filtered byte, CNT_W/8 trailer bytes carry the cycle count, most significant byte first. The block then returns to idle.
- R6: The cycle count is cleared when the echo is taken. It increases by one in each exchange cycle in which the filter is busy, up to and including the cycle that takes the last filtered byte. After that it stays frozen.
- R7: Cycles in which the filter busy input is low do not advance the count, even while link bytes are waiting.
- R8: While the transmitter holds ready low, a presented transmit byte stays valid with unchanged data until it is taken.
- R9: After reset, the receiver is ready, nothing is transmitted and the run indicator is low.
- R10: The filter ID output holds the most recently accepted command byte. The run indicator is high only during the exchange phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_ready_o | output | 1 | Receive byte accepted |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Transmitter ready |
| flt_id_o | output | 8 | Accepted filter ID |
| flt_run_o | output | 1 | Exchange phase active |
| flt_busy_i | input | 1 | Filter is computing this cycle |
| pix_in_valid_o | output | 1 | Pixel to filter valid |
| pix_in_data_o | output | 8 | Pixel to filter |
| pix_in_ready_i | input | 1 | Filter accepts pixel |
| pix_out_valid_i | input | 1 | Filtered pixel valid |
| pix_out_data_i | input | 8 | Filtered pixel |
| pix_out_ready_o | output | 1 | Filtered pixel accepted |

## Verification
The bench builds the block with ROWS=3 and COLS=4, so a frame is 12 bytes. With a frame that small, complete runs can be checked, including the row wrap and the point where the counter freezes on the last pixel. The full 32-bit trailer width is kept, so the byte order of all four trailer bytes is checked. Runs are repeated with random transmit stalls, link gaps and idle filter cycles, which makes the difference between busy cycles and waiting cycles show up in the expected count.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ECHO,
    ST_XFER,
    ST_TRAIL
  } seq_state_e;
endpackage

// File: rtl/seq_id_check.sv
module seq_id_check #(
  parameter int W      = 8,
  parameter int ID_MIN = 1,
  parameter int ID_MAX = 8
) (
  input  logic [W-1:0] id_i,
  output logic         ok_o
);
  localparam logic [W-1:0] LO = W'(ID_MIN);
  localparam logic [W-1:0] HI = W'(ID_MAX);

  assign ok_o = (id_i >= LO) && (id_i <= HI);
endmodule

// File: rtl/seq_frame_cnt.sv
module seq_frame_cnt #(
  parameter int ROWS = 256,
  parameter int COLS = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic done_o
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      col_q  <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      row_q  <= '0;
      col_q  <= '0;
      done_q <= 1'b0;
    end else if (step_i && !done_q) begin
      if (col_q == COL_LAST) begin
        col_q <= '0;
        if (row_q == ROW_LAST) begin
          row_q  <= '0;
          done_q <= 1'b1;
        end else begin
          row_q <= row_q + 1'b1;
        end
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign done_o = done_q;

  AST_COL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q <= COL_LAST); // R4
  AST_ROW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_q <= ROW_LAST); // R4
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !clr_i |=> done_q); // R4
endmodule

// File: rtl/seq_cyc_cnt.sv
module seq_cyc_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  // no wrap handling: a run stays far below 2^W cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i |=> cnt_o == W'($past(cnt_o) + 1'b1)); // R6
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !clr_i |=> $stable(cnt_o)); // R7
  AST_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0); // R6
endmodule

// File: rtl/seq_run_top.sv
module seq_run_top
  import seq_pkg::*;
#(
  parameter int ROWS   = 256,
  parameter int COLS   = 256,
  parameter int CNT_W  = 32,
  parameter int ID_MIN = 1,
  parameter int ID_MAX = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  output logic       rx_ready_o,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  input  logic       tx_ready_i,
  output logic [7:0] flt_id_o,
  output logic       flt_run_o,
  input  logic       flt_busy_i,
  output logic       pix_in_valid_o,
  output logic [7:0] pix_in_data_o,
  input  logic       pix_in_ready_i,
  input  logic       pix_out_valid_i,
  input  logic [7:0] pix_out_data_i,
  output logic       pix_out_ready_o
);
  localparam int TRL_BYTES = CNT_W / 8;
  localparam int TRL_W     = (TRL_BYTES > 1) ? $clog2(TRL_BYTES) : 1;
  localparam logic [TRL_W-1:0] TRL_LAST = TRL_W'(TRL_BYTES - 1);

  seq_state_e       st_q;
  logic [7:0]       id_q;
  logic [TRL_W-1:0] trl_idx_q;
  logic             id_ok;
  logic             in_done, out_done;
  logic             rx_take, tx_take, in_take, out_take;
  logic             echo_take, cyc_en;
  logic [CNT_W-1:0] cyc_cnt, trl_sh;

  seq_id_check #(.W(8), .ID_MIN(ID_MIN), .ID_MAX(ID_MAX)) i_id_check (
    .id_i (rx_data_i),
    .ok_o (id_ok)
  );

  seq_frame_cnt #(.ROWS(ROWS), .COLS(COLS)) i_in_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (echo_take),
    .step_i (in_take),
    .done_o (in_done)
  );

  seq_frame_cnt #(.ROWS(ROWS), .COLS(COLS)) i_out_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (echo_take),
    .step_i (out_take),
    .done_o (out_done)
  );

  seq_cyc_cnt #(.W(CNT_W)) i_cyc_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (echo_take),
    .en_i   (cyc_en),
    .cnt_o  (cyc_cnt)
  );

  assign trl_sh = cyc_cnt >> (8 * (TRL_BYTES - 1 - int'(trl_idx_q)));

  always_comb begin
    rx_ready_o      = 1'b0;
    tx_valid_o      = 1'b0;
    tx_data_o       = 8'h00;
    pix_in_valid_o  = 1'b0;
    pix_out_ready_o = 1'b0;
    unique case (st_q)
      ST_IDLE: rx_ready_o = 1'b1;
      ST_ECHO: begin
        tx_valid_o = 1'b1;
        tx_data_o  = id_q;
      end
      ST_XFER: begin
        pix_in_valid_o  = rx_valid_i && !in_done;
        rx_ready_o      = pix_in_ready_i && !in_done;
        tx_valid_o      = pix_out_valid_i && !out_done;
        tx_data_o       = pix_out_data_i;
        pix_out_ready_o = tx_ready_i && !out_done;
      end
      ST_TRAIL: begin
        tx_valid_o = 1'b1;
        tx_data_o  = trl_sh[7:0];
      end
      default: ;
    endcase
  end

  assign pix_in_data_o = rx_data_i;
  assign rx_take   = rx_valid_i && rx_ready_o;
  assign tx_take   = tx_valid_o && tx_ready_i;
  assign in_take   = (st_q == ST_XFER) && pix_in_valid_o && pix_in_ready_i;
  assign out_take  = (st_q == ST_XFER) && pix_out_valid_i && pix_out_ready_o;
  assign echo_take = (st_q == ST_ECHO) && tx_ready_i;
  assign cyc_en    = (st_q == ST_XFER) && flt_busy_i && !out_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      id_q      <= 8'h00;
      trl_idx_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE:
          if (rx_take && id_ok) begin
            id_q <= rx_data_i;
            st_q <= ST_ECHO;
          end
        ST_ECHO:
          if (echo_take) st_q <= ST_XFER;
        ST_XFER:
          if (in_done && out_done) begin
            trl_idx_q <= '0;
            st_q      <= ST_TRAIL;
          end
        ST_TRAIL:
          if (tx_take) begin
            if (trl_idx_q == TRL_LAST) st_q <= ST_IDLE;
            else trl_idx_q <= trl_idx_q + 1'b1;
          end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign flt_id_o  = id_q;
  assign flt_run_o = (st_q == ST_XFER);

  AST_ECHO_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_ECHO && tx_ready_i |=> st_q == ST_XFER); // R1
  AST_RUN_ID_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_XFER |-> id_q >= 8'(ID_MIN) && id_q <= 8'(ID_MAX)); // R1
  AST_NO_RX_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ECHO || st_q == ST_TRAIL) |-> !rx_ready_o && !pix_in_valid_o); // R2
  AST_BAD_ID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_IDLE && rx_valid_i && !id_ok |=> st_q == ST_IDLE && $stable(id_q)); // R3
  AST_TRAIL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_TRAIL |=> $stable(cyc_cnt)); // R6
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_XFER) && tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)); // R8
endmodule

// File: tb/test_seq_run_top.sv
module test_seq_run_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 3;
  localparam int COLS = 4;
  localparam int N    = ROWS * COLS;
  localparam int TRL  = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_valid_i = 1'b0, tx_ready_i = 1'b1, flt_busy_i = 1'b0;
  logic pix_in_ready_i = 1'b1, pix_out_valid_i = 1'b0;
  logic [7:0] rx_data_i = 8'h00, pix_out_data_i = 8'h00;
  logic rx_ready_o, tx_valid_o, flt_run_o, pix_in_valid_o, pix_out_ready_o;
  logic [7:0] tx_data_o, flt_id_o, pix_in_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_run_top #(.ROWS(ROWS), .COLS(COLS), .CNT_W(32)) i_seq_run_top (
    .clk_i(clk), .rst_ni(rst_ni),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_ready_o(rx_ready_o),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i),
    .flt_id_o(flt_id_o), .flt_run_o(flt_run_o), .flt_busy_i(flt_busy_i),
    .pix_in_valid_o(pix_in_valid_o), .pix_in_data_o(pix_in_data_o),
    .pix_in_ready_i(pix_in_ready_i),
    .pix_out_valid_i(pix_out_valid_i), .pix_out_data_i(pix_out_data_i),
    .pix_out_ready_o(pix_out_ready_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] host_q [0:63];
  logic [7:0] in_q   [0:63];
  logic [7:0] tx_log [0:63];
  int host_len = 0, host_idx = 0, n_in = 0, n_out = 0, tx_cnt = 0;
  int exp_cyc = 0, hold_err = 0, order_err = 0;
  bit tx_stall = 0, rx_gap = 0, busy_gap = 0;
  logic [7:0] lfsr = 8'h5A;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // host, filter model and transmit sink; sample at negedge, apply after posedge
  always begin : model
    bit tk_rx, tk_in, tk_out, tk_tx, prev_stall;
    logic [7:0] in_b, tx_b, prev_data;
    prev_stall = 0;
    prev_data  = 8'h00;
    forever begin
      @(negedge clk);
      tk_rx  = rx_valid_i && rx_ready_o;
      tk_in  = pix_in_valid_o && pix_in_ready_i;
      tk_out = pix_out_valid_i && pix_out_ready_o;
      tk_tx  = tx_valid_o && tx_ready_i;
      if (tk_in && tx_cnt == 0) order_err++;
      if (prev_stall && !(tx_valid_o && tx_data_o == prev_data)) hold_err++;
      prev_stall = tx_valid_o && !tx_ready_i;
      prev_data  = tx_data_o;
      if (tx_cnt >= 1 && tx_cnt - 1 < N && flt_busy_i) exp_cyc++;
      in_b = pix_in_data_o;
      tx_b = tx_data_o;
      @(posedge clk);
      #1;
      if (tk_rx) host_idx++;
      if (tk_in && n_in < 64) begin in_q[n_in] = in_b; n_in++; end
      if (tk_out) n_out++;
      if (tk_tx && tx_cnt < 64) begin tx_log[tx_cnt] = tx_b; tx_cnt++; end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rx_valid_i      = (host_idx < host_len) && !(rx_gap && lfsr[2]);
      rx_data_i       = (host_idx < 64) ? host_q[host_idx] : 8'h00;
      pix_in_ready_i  = rx_gap ? lfsr[3] : 1'b1;
      pix_out_valid_i = (n_out < n_in);
      pix_out_data_i  = 8'hFF - in_q[n_out % 64];
      flt_busy_i      = busy_gap ? lfsr[1] : 1'b1;
      tx_ready_i      = tx_stall ? lfsr[0] : 1'b1;
    end
  end

  task automatic clear_state();
    @(posedge clk);
    #2;
    host_len = 0; host_idx = 0; n_in = 0; n_out = 0; tx_cnt = 0;
    exp_cyc = 0; hold_err = 0; order_err = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rx_ready_o == 1'b1, "R9", "rx_ready in reset", rx_ready_o, 1);
    chk(tx_valid_o == 1'b0, "R9", "tx_valid in reset", tx_valid_o, 0);
    chk(flt_run_o == 1'b0, "R9", "run in reset", flt_run_o, 0);
  endtask

  task automatic t_bad_id();
    clear_state();
    host_q[0] = 8'h00; host_q[1] = 8'h09; host_q[2] = 8'hFF;
    host_len = 3;
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(host_idx == 3, "R3", "bad ids consumed", host_idx, 3);
    chk(tx_cnt == 0, "R3", "no echo for bad id", tx_cnt, 0);
    chk(flt_run_o == 1'b0, "R3", "run stays low", flt_run_o, 0);
    chk(rx_ready_o == 1'b1, "R3", "receiver stays ready", rx_ready_o, 1);
  endtask

  task automatic t_run(input logic [7:0] id, input bit ts, input bit rg,
                       input bit bg, input int seed);
    int waited;
    int bad_pix;
    longint trl;
    clear_state();
    tx_stall = ts; rx_gap = rg; busy_gap = bg;
    host_q[0] = id;
    for (int i = 0; i < N; i++) host_q[1 + i] = 8'((i * 37 + seed) & 8'hFF);
    host_len = 1 + N;
    waited = 0;
    while (tx_cnt < N + 1 + TRL && waited < 3000) begin
      @(posedge clk);
      waited++;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tx_cnt == N + 1 + TRL, "R4", "bytes transmitted", tx_cnt, N + 1 + TRL);
    chk(tx_log[0] == id, "R1", "echo byte", tx_log[0], id);
    chk(order_err == 0, "R2", "pixel before echo", order_err, 0);
    bad_pix = 0;
    for (int i = 0; i < N; i++)
      if (tx_log[1 + i] !== 8'hFF - host_q[1 + i]) bad_pix++;
    chk(bad_pix == 0, "R4", "filtered pixel mismatches", bad_pix, 0);
    chk(n_in == N, "R4", "pixels to filter", n_in, N);
    trl = 0;
    for (int i = 0; i < TRL; i++) trl = (trl << 8) | longint'(tx_log[1 + N + i]);
    chk(trl == longint'(exp_cyc), bg ? "R7" : "R6", "cycle trailer MSB first",
        trl, exp_cyc);
    chk(trl != 0, "R5", "trailer nonzero", trl, exp_cyc);
    chk(hold_err == 0, "R8", "tx stall hold violations", hold_err, 0);
    chk(flt_id_o == id, "R10", "filter id held", flt_id_o, id);
    chk(flt_run_o == 1'b0 && rx_ready_o == 1'b1, "R5", "back to idle",
        {flt_run_o, rx_ready_o}, 2'b01);
    tx_stall = 0; rx_gap = 0; busy_gap = 0;
  endtask

  task automatic t_run_flag();
    int seen_run;
    int waited;
    clear_state();
    host_q[0] = 8'h03;
    for (int i = 0; i < N; i++) host_q[1 + i] = 8'(i);
    host_len = 1 + N;
    seen_run = 0;
    waited = 0;
    while (tx_cnt < N + 1 + TRL && waited < 3000) begin
      @(negedge clk);
      if (flt_run_o && tx_cnt >= 1 && tx_cnt <= N) seen_run++;
      waited++;
    end
    chk(seen_run > 0, "R10", "run high during exchange", seen_run, 1);
    repeat (3) @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    t_reset();
    #1 rst_ni = 1'b1;
    repeat (2) @(posedge clk);
    t_bad_id();
    t_run(8'h01, 0, 0, 0, 11);
    t_run(8'h08, 1, 0, 0, 90);
    t_run(8'h05, 1, 1, 1, 201);
    t_run(8'h02, 0, 1, 1, 7);
    t_run_flag();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule